// File: doc/BRIEF.md
# Routed Level Interrupt Controller

This block gathers a set of level-sensitive interrupt requests and steers each one onto one of several shared output lines. Every input has its own 4-bit selector in a bank of routing registers. A selector of zero leaves the input unconnected. Any other value names the output it drives. A global enable register gates each input. A read-only status word shows which requests are both raised and enabled.

Software reaches the registers through a plain synchronous bus with a word address, a write strobe, write data and registered read data. Each output line is the OR of every enabled, raised input routed to it. The output lines are registered.

Top module: `irq_router`

## Requirements
- R1: Word address 0 is the enable register. It is read/write, and bit n set lets input n through.
- R2: Word address 1 is the status word and returns irq_in AND enable. Writes to it change nothing.
- R3: Routing registers sit at word addresses 2 to 5 (byte offsets 0x08 to 0x14), in reversed order. Input n's selector is held in word 5 - n/8, at bits 4*(n%8)+3 down to 4*(n%8). Input 31 is therefore bits 31:28 of word 2, and input 0 is bits 3:0 of word 5.
- R4: An input whose selector is 0 drives no output, even when it is enabled and raised.
- R5: An input with selector s, where s is between 1 and 15, drives irq_out[s-1].
- R6: irq_out[k] is high while at least one enabled, raised input has selector k+1. Several inputs may share one output.
- R7: When the enable register is zero, every output is low.
- R8: A synchronous reset clears the enable register and all routing registers, and drives every output low.
- R9: bus_rdata presents the word addressed in the previous cycle. irq_out reflects the inputs, enable and routing state of the previous cycle.
- R10: Writing one routing register leaves the other routing registers unchanged. Each register reads back exactly the value last written to it.
- R11: Word addresses 6 and 7 read as zero, and writes to them have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 3 | Word address |
| bus_we | input | 1 | Write strobe |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| irq_in | input | 32 | Level interrupt requests |
| irq_out | output | 15 | Routed output lines |

## Verification
The bench fills the routing bank with patterns that place each input at a known field position. Input 31 is routed to the last output and input 0 to the first, so a controller that reverses the field order or the register order sends those requests to the wrong line. Selector-zero inputs and a masked input are raised beside routed ones. A decoder off by one would light a neighbouring output, and a design that ignores the enable bit would light the output of the masked input. Several inputs are merged onto one output, and each routing register is read back after a write to a different one, which exposes clobbered neighbours. The bench also checks status and reserved addresses after writes, and the one-cycle output latency right after an input change.

// File: rtl/irq_router_pkg.sv
package irq_router_pkg;
  // word addresses of the register file
  localparam int unsigned MASK_WORD = 0;
  localparam int unsigned PEND_WORD = 1;
  localparam int unsigned RT_BASE   = 2;
endpackage

// File: rtl/irq_router_regs.sv
module irq_router_regs
  import irq_router_pkg::*;
#(
  parameter int unsigned NUM_IN = 32,
  parameter int unsigned SEL_W  = 4,
  parameter int unsigned BUS_W  = 32,
  parameter int unsigned ADDR_W = 3
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic [ADDR_W-1:0]         bus_addr,
  input  logic                      bus_we,
  input  logic [BUS_W-1:0]          bus_wdata,
  output logic [BUS_W-1:0]          bus_rdata,
  input  logic [NUM_IN-1:0]         irq_in,
  output logic [NUM_IN-1:0]         mask,
  output logic [NUM_IN*SEL_W-1:0]   route_flat
);
  localparam int unsigned FIELDS = BUS_W / SEL_W;
  localparam int unsigned NUM_RT = NUM_IN / FIELDS;

  logic [BUS_W-1:0] rt_q [NUM_RT];
  logic [BUS_W-1:0] rd_next;

  always_ff @(posedge clk) begin
    if (rst) mask <= '0;
    else if (bus_we && bus_addr == ADDR_W'(MASK_WORD)) mask <= bus_wdata[NUM_IN-1:0];
  end

  for (genvar r = 0; r < NUM_RT; r++) begin : g_rt
    always_ff @(posedge clk) begin
      if (rst) rt_q[r] <= '0;
      else if (bus_we && bus_addr == ADDR_W'(RT_BASE + r)) rt_q[r] <= bus_wdata;
    end

    // R10: other writes and idle cycles leave this register alone
    a_r10_route_hold: assert property (@(posedge clk) disable iff (rst)
      !(bus_we && bus_addr == ADDR_W'(RT_BASE + r)) |=> $stable(rt_q[r]));
  end

  // reversed register order: input n sits in register NUM_RT-1-n/FIELDS
  for (genvar n = 0; n < NUM_IN; n++) begin : g_flat
    assign route_flat[n*SEL_W +: SEL_W] =
      rt_q[NUM_RT-1-(n/FIELDS)][(n%FIELDS)*SEL_W +: SEL_W];
  end

  always_comb begin
    rd_next = '0;
    if (bus_addr == ADDR_W'(MASK_WORD)) rd_next[NUM_IN-1:0] = mask;
    if (bus_addr == ADDR_W'(PEND_WORD)) rd_next[NUM_IN-1:0] = irq_in & mask;
    for (int r = 0; r < NUM_RT; r++)
      if (bus_addr == ADDR_W'(RT_BASE + r)) rd_next = rt_q[r];
  end

  always_ff @(posedge clk) begin
    if (rst) bus_rdata <= '0;
    else     bus_rdata <= rd_next;
  end

  // R1: an enable-register write lands the next cycle
  a_r1_mask_write: assert property (@(posedge clk) disable iff (rst)
    (bus_we && bus_addr == ADDR_W'(MASK_WORD)) |=> mask == $past(bus_wdata[NUM_IN-1:0]));

  // R2: the status word reports the enabled, raised requests
  a_r2_pending_read: assert property (@(posedge clk) disable iff (rst)
    (bus_addr == ADDR_W'(PEND_WORD)) |=> bus_rdata[NUM_IN-1:0] == $past(irq_in & mask));
endmodule

// File: rtl/irq_router_fanout.sv
module irq_router_fanout #(
  parameter int unsigned NUM_IN  = 32,
  parameter int unsigned SEL_W   = 4,
  parameter int unsigned NUM_OUT = 15
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic [NUM_IN-1:0]       irq_in,
  input  logic [NUM_IN-1:0]       mask,
  input  logic [NUM_IN*SEL_W-1:0] route_flat,
  output logic [NUM_OUT-1:0]      irq_out
);
  logic [NUM_IN-1:0]  live;
  logic [NUM_OUT-1:0] out_next;

  assign live = irq_in & mask;

  // one OR tree per output line; selector k+1 picks line k
  for (genvar k = 0; k < NUM_OUT; k++) begin : g_line
    logic hit;
    always_comb begin
      hit = 1'b0;
      for (int n = 0; n < NUM_IN; n++)
        if (live[n] && route_flat[n*SEL_W +: SEL_W] == SEL_W'(k + 1)) hit = 1'b1;
    end
    assign out_next[k] = hit;
  end

  always_ff @(posedge clk) begin
    if (rst) irq_out <= '0;
    else     irq_out <= out_next;
  end

  // R6: there are never more lit lines than live requests
  a_r6_count_bound: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> $countones(irq_out) <= $countones($past(live)));
endmodule

// File: rtl/irq_router.sv
module irq_router
  import irq_router_pkg::*;
#(
  parameter int unsigned NUM_IN = 32,
  parameter int unsigned SEL_W  = 4,
  localparam int unsigned BUS_W   = 32,
  localparam int unsigned NUM_OUT = (1 << SEL_W) - 1,
  localparam int unsigned NUM_RT  = NUM_IN / (BUS_W / SEL_W),
  localparam int unsigned ADDR_W  = $clog2(RT_BASE + NUM_RT)
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [ADDR_W-1:0]  bus_addr,
  input  logic               bus_we,
  input  logic [BUS_W-1:0]   bus_wdata,
  output logic [BUS_W-1:0]   bus_rdata,
  input  logic [NUM_IN-1:0]  irq_in,
  output logic [NUM_OUT-1:0] irq_out
);
  logic [NUM_IN-1:0]       mask;
  logic [NUM_IN*SEL_W-1:0] route_flat;

  irq_router_regs #(.NUM_IN(NUM_IN), .SEL_W(SEL_W), .BUS_W(BUS_W), .ADDR_W(ADDR_W)) u_regs (
    .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_we(bus_we),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq_in(irq_in),
    .mask(mask), .route_flat(route_flat)
  );

  irq_router_fanout #(.NUM_IN(NUM_IN), .SEL_W(SEL_W), .NUM_OUT(NUM_OUT)) u_fanout (
    .clk(clk), .rst(rst), .irq_in(irq_in), .mask(mask),
    .route_flat(route_flat), .irq_out(irq_out)
  );

  // R7: with every input disabled, all lines drop the next cycle
  a_r7_mask_blocks: assert property (@(posedge clk) disable iff (rst)
    (mask == '0) |=> irq_out == '0);

  // R8: the cycle after reset, every line is low
  a_r8_reset_low: assert property (@(posedge clk) disable iff (rst)
    $fell(rst) |-> irq_out == '0);
endmodule

// File: tb/irq_router_test.sv
module irq_router_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [2:0]  bus_addr = '0;
  logic        bus_we = 1'b0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [31:0] irq_in = '0;
  logic [14:0] irq_out;
  int total = 0;
  int bad = 0;
  bit done = 0;

  always #5 clk = ~clk;

  irq_router uut (
    .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_we(bus_we),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq_in(irq_in), .irq_out(irq_out)
  );

  // configuration used by the vector table
  localparam logic [31:0] CFG_MASK = 32'hFFFF_FFDF;   // input 5 disabled
  localparam logic [31:0] CFG_RT2  = 32'hF000_0000;   // 31 -> out14, 24..30 off
  localparam logic [31:0] CFG_RT3  = 32'h1111_1111;   // 16..23 -> out0
  localparam logic [31:0] CFG_RT4  = 32'hFEDC_BA90;   // 8 off, 9..15 -> out8..14
  localparam logic [31:0] CFG_RT5  = 32'h8765_4321;   // 0..7 -> out0..7

  localparam int NV = 11;
  localparam logic [31:0] VIN [NV] = '{
    32'h0000_0001, 32'h0000_0020, 32'h0000_0100, 32'h0000_0200,
    32'h0000_8000, 32'h8000_0000, 32'h4000_0000, 32'h0001_0000,
    32'h0000_00DF, 32'hFFFF_FFFF, 32'h00FF_0000 };
  localparam logic [14:0] VOUT [NV] = '{
    15'h0001, 15'h0000, 15'h0000, 15'h0100,
    15'h4000, 15'h4000, 15'h0000, 15'h0001,
    15'h00DF, 15'h7FDF, 15'h0001 };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic bus_write(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_we = 1'b1;
    @(negedge clk);
    bus_we = 1'b0;
  endtask

  task automatic bus_read(input logic [2:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_addr = a;
    @(negedge clk);
    d = bus_rdata;
  endtask

  initial begin
    #1_000_000;
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [31:0] rd;
    irq_in = 32'hFFFF_FFFF;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R8: reset leaves lines low and registers clear
    @(negedge clk);
    check("R8 out after reset", {17'd0, irq_out}, 32'd0);
    bus_read(3'd0, rd); check("R8 mask reset", rd, 32'd0);
    bus_read(3'd5, rd); check("R8 route reset", rd, 32'd0);
    check("R8 still low", {17'd0, irq_out}, 32'd0);
    irq_in = '0;

    // R3 / R10: program routing, read back each
    bus_write(3'd2, CFG_RT2);
    bus_write(3'd3, CFG_RT3);
    bus_write(3'd4, CFG_RT4);
    bus_write(3'd5, CFG_RT5);
    bus_write(3'd0, CFG_MASK);
    bus_read(3'd2, rd); check("R10 rt word2", rd, CFG_RT2);
    bus_read(3'd3, rd); check("R10 rt word3", rd, CFG_RT3);
    bus_read(3'd4, rd); check("R10 rt word4", rd, CFG_RT4);
    bus_read(3'd5, rd); check("R10 rt word5", rd, CFG_RT5);
    bus_read(3'd0, rd); check("R1 mask readback", rd, CFG_MASK);

    // R3 R4 R5 R6: vector table
    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      irq_in = VIN[i];
      @(negedge clk);
      check($sformatf("R5 R6 vector %0d", i), {17'd0, irq_out}, {17'd0, VOUT[i]});
    end

    // R9: output changes one clock after an input change
    @(negedge clk); irq_in = '0;
    @(negedge clk); irq_in = 32'h0000_0004;
    #1 check("R9 before edge", {17'd0, irq_out}, 32'd0);
    @(negedge clk);
    check("R9 after edge", {17'd0, irq_out}, 32'h0000_0004);

    // R2: status read and ignored write
    irq_in = 32'h0000_0321;
    bus_read(3'd1, rd); check("R2 pending", rd, 32'h0000_0301);
    bus_write(3'd1, 32'hFFFF_FFFF);
    bus_read(3'd0, rd); check("R2 write leaves mask", rd, CFG_MASK);
    bus_read(3'd1, rd); check("R2 pending after write", rd, 32'h0000_0301);

    // R11: reserved words
    bus_write(3'd6, 32'hDEAD_BEEF);
    bus_write(3'd7, 32'h1234_5678);
    bus_read(3'd6, rd); check("R11 word6 zero", rd, 32'd0);
    bus_read(3'd7, rd); check("R11 word7 zero", rd, 32'd0);
    bus_read(3'd5, rd); check("R11 rt untouched", rd, CFG_RT5);

    // R10: single-register write isolation
    bus_write(3'd4, 32'h0000_0002);
    bus_read(3'd3, rd); check("R10 neighbour word3", rd, CFG_RT3);
    bus_read(3'd5, rd); check("R10 neighbour word5", rd, CFG_RT5);
    bus_read(3'd4, rd); check("R10 word4 new", rd, 32'h0000_0002);
    irq_in = 32'h0000_0200; // input 9 now selector 0
    @(negedge clk); @(negedge clk);
    check("R4 disconnected after rewrite", {17'd0, irq_out}, 32'd0);
    irq_in = 32'h0000_0100; // input 8 now selector 2 -> out1
    @(negedge clk); @(negedge clk);
    check("R3 R5 input8 field", {17'd0, irq_out}, 32'h0000_0002);

    // R7: global disable blocks all
    irq_in = 32'hFFFF_FFFF;
    bus_write(3'd0, 32'd0);
    @(negedge clk);
    check("R7 all blocked", {17'd0, irq_out}, 32'd0);
    bus_read(3'd1, rd); check("R7 pending zero", rd, 32'd0);

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule